// File: doc/BRIEF.md
# Level-Triggered EOI Storm Throttle

This block is the end-of-interrupt path of a 24-input interrupt controller. Each input pin has its own routing entry, made of an 8-bit vector, a trigger-mode flag, a mask flag and a remote-IRR flag that records an interrupt in service. The block samples the raw level of every input line. A level-mode pin whose line rises is delivered when it is unmasked and has no interrupt in service. Deliveries leave the block one at a time on a valid/ready output that carries the vector.

When a processor signals end of interrupt for a vector, every level-mode entry with that vector and with remote-IRR set has the flag cleared. If such an entry is unmasked and its line is still high, the interrupt is raised again at once. A handler may acknowledge before it clears the cause of the interrupt. In that case this loop never ends, so each pin counts its back-to-back re-raises. At a programmable limit the counter restarts, and the re-raise waits on a shared timer. When the timer expires, a service pass runs over all pins, and the guest gets time to remove the cause.

Top module: `eoi_storm_throttle`

## Requirements
- R1: After reset every pin is masked, no interrupt is in service, all counters are zero and the timer is idle, so raising input lines produces no delivery.
- R2: A configuration write to pin `cfg_pin` sets its vector, trigger mode (`cfg_level` 1 = level, 0 = edge) and mask (`cfg_mask` 1 = masked), and leaves remote-IRR unchanged. Edge-mode pins are never delivered.
- R3: A rising input line on an unmasked level-mode pin with remote-IRR clear produces one delivery of that pin's vector. The pin's remote-IRR is set when the delivery is accepted.
- R4: An end of interrupt for vector V acts only on level-mode entries whose vector equals V and whose remote-IRR is set. Every other entry keeps its state.
- R5: When an entry acted on is unmasked and its line is still high, its vector is delivered again and its re-raise counter increments.
- R6: When an entry acted on is masked or its line is low, no delivery follows and its counter returns to zero. Unmasking later with the line steady high does not deliver.
- R7: The re-raise that would bring a pin's counter to STORM_LIMIT (4 in the bench) sets the counter to zero and is not issued. The timer is armed instead, and the vector is delivered exactly DELAY_CYCLES + 1 cycles after the end-of-interrupt edge.
- R8: One timer serves all pins. Arming it while it runs keeps the earlier deadline.
- R9: On timer expiry every unmasked, level-mode pin with a high line and remote-IRR clear is delivered, in ascending pin order.
- R10: At most one delivery is outstanding. `dlv_valid` and `dlv_vector` hold steady until `dlv_ready` is seen.
- R11: Pins that request in the same cycle are delivered in ascending pin-index order.
- R12: Counters and remote-IRR are kept per pin, even for vectors above 23. One end of interrupt re-raises every pin that shares its vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one pin's routing entry |
| cfg_pin | input | 5 | Pin index being written |
| cfg_vector | input | 8 | Vector to store |
| cfg_level | input | 1 | Trigger mode, 1 = level |
| cfg_mask | input | 1 | Mask, 1 = masked |
| irq_line | input | 24 | Raw input lines, one per pin |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector being retired |
| dlv_valid | output | 1 | Delivery request |
| dlv_vector | output | 8 | Vector of the delivery |
| dlv_ready | input | 1 | Delivery accepted |

## Verification
The hardest case to reach is the shared timer being armed a second time while it is already counting. This needs two different pins to build up full storms and then defer in turn a few cycles apart. A third pin must also be left unmasked with its line high and remote-IRR clear but nothing pending, so that only the expiry pass can deliver it. The stimulus gets there with a small storm limit. It runs several strict end-of-interrupt/acknowledge rounds on two vectors. Earlier, a pin is parked with a masked end of interrupt and then unmasked. The final deferrals are timed against a cycle counter, so a restarted deadline shows up as a late delivery.

// File: rtl/eoi_pkg.sv
// Shared types for the EOI storm throttle.
// Assumes an 8-bit interrupt vector; the pin count is a top-level parameter.
package eoi_pkg;
    localparam int VEC_W = 8;

    typedef logic [VEC_W-1:0] vec_t;

    // Software-visible part of one pin's routing entry.
    typedef struct packed {
        vec_t vector;
        logic level;
        logic mask;
    } pin_cfg_t;
endpackage

// File: rtl/eoi_delay_timer.sv
// Single countdown timer shared by all pins.
// Arming while running is ignored, so the first deadline always wins.
// fire is a one-cycle pulse DELAY_CYCLES edges after the arming edge.
module eoi_delay_timer #(
    parameter int DELAY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    localparam int TMR_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [TMR_W-1:0] LOAD = TMR_W'(DELAY_CYCLES - 1);

    logic             running_q;
    logic [TMR_W-1:0] tcnt_q;

    // Expiry is the last count of a running timer.
    assign fire = running_q && (tcnt_q == '0);

    // Count down, stop on expiry, load only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            tcnt_q    <= '0;
        end else if (fire) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            tcnt_q <= tcnt_q - 1'b1;
        end else if (arm) begin
            running_q <= 1'b1;
            tcnt_q    <= LOAD;
        end
    end

    assert_keep_deadline_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !fire) |=> (running_q && tcnt_q == $past(tcnt_q) - 1'b1));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !running_q);
endmodule

// File: rtl/eoi_pin_slice.sv
// State and EOI decision for one input pin.
// Holds the routing entry, remote-IRR, the re-raise counter and a pending flag.
// Assumes grant and accept never arrive while remote-IRR is set.
module eoi_pin_slice
    import eoi_pkg::*;
#(
    parameter int STORM_LIMIT = 10000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  pin_cfg_t cfg,
    input  logic     line,
    input  logic     eoi_valid,
    input  vec_t     eoi_vector,
    input  logic     grant,
    input  logic     accept,
    input  logic     inflight,
    input  logic     timer_fire,
    output vec_t     vec,
    output logic     req,
    output logic     defer
);
    localparam int CNT_W = (STORM_LIMIT > 2) ? $clog2(STORM_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(STORM_LIMIT - 1);

    vec_t             vec_q;
    logic             level_q;
    logic             mask_q;
    logic             rirr_q;
    logic             line_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    logic eoi_hit;
    logic live;
    logic at_limit;
    logic redeliver;
    logic eligible;
    logic rise;
    logic set_pend;

    // EOI decision for this pin.
    always_comb begin
        eoi_hit   = eoi_valid && level_q && rirr_q && (vec_q == eoi_vector);
        live      = !mask_q && line;
        at_limit  = (cnt_q == LIMIT_M1);
        redeliver = eoi_hit && live && !at_limit;
        defer     = eoi_hit && live && at_limit;
        eligible  = level_q && !mask_q && line && !rirr_q && !inflight;
        rise      = line && !line_q;
        set_pend  = (rise || redeliver || timer_fire) && !inflight;
        req       = pend_q && eligible;
        vec       = vec_q;
    end

    // Routing entry fields, masked at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            level_q <= 1'b0;
            mask_q  <= 1'b1;
        end else if (cfg_we) begin
            vec_q   <= cfg.vector;
            level_q <= cfg.level;
            mask_q  <= cfg.mask;
        end
    end

    // Remote-IRR: set on accepted delivery, cleared by a matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)       rirr_q <= 1'b0;
        else if (accept)  rirr_q <= 1'b1;
        else if (eoi_hit) rirr_q <= 1'b0;
    end

    // Successive re-raise counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (eoi_hit) begin
            if (live && !at_limit) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    // Line history for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line;
    end

    // Pending request: cleared on grant, dropped when no longer eligible.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (grant)     pend_q <= 1'b0;
        else if (set_pend)  pend_q <= 1'b1;
        else if (!eligible) pend_q <= 1'b0;
    end

    assert_eoi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && level_q && rirr_q && vec_q == eoi_vector) |=> !rirr_q);

    assert_eoi_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && (eoi_vector != vec_q || !level_q) && !accept) |=> $stable(rirr_q));

    assert_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && (mask_q || !line)) |=> (cnt_q == '0));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_M1);

    assert_grant_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (level_q && !mask_q && !rirr_q));
endmodule

// File: rtl/eoi_deliver_arb.sv
// Lowest-index arbiter with a single-entry delivery register.
// A new pin is picked only when the output register is empty.
module eoi_deliver_arb
    import eoi_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      req,
    input  vec_t [NPINS-1:0]      vecs,
    input  logic                  dlv_ready,
    output logic [NPINS-1:0]      grant,
    output logic [NPINS-1:0]      accept,
    output logic [NPINS-1:0]      inflight,
    output logic                  dlv_valid,
    output vec_t                  dlv_vector
);
    logic             valid_q;
    logic [NPINS-1:0] sel_q;
    vec_t             vec_q;
    vec_t             pick_vec;
    logic             found;
    logic             take;

    // Pick the lowest requesting pin while the output is free.
    always_comb begin
        grant    = '0;
        pick_vec = '0;
        found    = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (!valid_q && req[i] && !found) begin
                grant[i] = 1'b1;
                pick_vec = vecs[i];
                found    = 1'b1;
            end
        end
    end

    // Handshake bookkeeping toward the pins.
    always_comb begin
        take       = valid_q && dlv_ready;
        accept     = take ? sel_q : '0;
        inflight   = sel_q;
        dlv_valid  = valid_q;
        dlv_vector = vec_q;
    end

    // Output register: load on grant, empty on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sel_q   <= '0;
            vec_q   <= '0;
        end else if (take) begin
            valid_q <= 1'b0;
            sel_q   <= '0;
        end else if (found) begin
            valid_q <= 1'b1;
            sel_q   <= grant;
            vec_q   <= pick_vec;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !dlv_ready) |=> (valid_q && $stable(vec_q)));

    assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q) && (valid_q == (sel_q != '0)));
endmodule

// File: rtl/eoi_storm_throttle.sv
// Top of the EOI storm throttle: one slice per pin, a shared delay timer
// and the delivery arbiter. Any pin reaching its storm limit arms the timer;
// timer expiry asks every pin for a service pass.
module eoi_storm_throttle
    import eoi_pkg::*;
#(
    parameter int NPINS        = 24,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 1250000,
    localparam int PIN_W       = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PIN_W-1:0] cfg_pin,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic             cfg_level,
    input  logic             cfg_mask,
    input  logic [NPINS-1:0] irq_line,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output logic             dlv_valid,
    output logic [VEC_W-1:0] dlv_vector,
    input  logic             dlv_ready
);
    pin_cfg_t         cfg_word;
    logic [NPINS-1:0] req;
    logic [NPINS-1:0] defer;
    logic [NPINS-1:0] grant;
    logic [NPINS-1:0] accept;
    logic [NPINS-1:0] inflight;
    vec_t [NPINS-1:0] vecs;
    logic             timer_fire;
    logic             arm;

    // Pack the configuration fields and merge the deferral requests.
    always_comb begin
        cfg_word = '{vector: cfg_vector, level: cfg_level, mask: cfg_mask};
        arm      = |defer;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        eoi_pin_slice #(
            .STORM_LIMIT(STORM_LIMIT)
        ) i_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_pin == PIN_W'(p))),
            .cfg        (cfg_word),
            .line       (irq_line[p]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant      (grant[p]),
            .accept     (accept[p]),
            .inflight   (inflight[p]),
            .timer_fire (timer_fire),
            .vec        (vecs[p]),
            .req        (req[p]),
            .defer      (defer[p])
        );
    end

    eoi_delay_timer #(
        .DELAY_CYCLES(DELAY_CYCLES)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .fire  (timer_fire)
    );

    eoi_deliver_arb #(
        .NPINS(NPINS)
    ) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .vecs       (vecs),
        .dlv_ready  (dlv_ready),
        .grant      (grant),
        .accept     (accept),
        .inflight   (inflight),
        .dlv_valid  (dlv_valid),
        .dlv_vector (dlv_vector)
    );

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: tb/test_eoi_storm_throttle.sv
// Scoreboard bench: stimulus tasks queue expected vectors, a monitor
// pops and compares them at each accepted delivery.
module test_eoi_storm_throttle;
    localparam int NPINS = 24;
    localparam int LIMIT = 4;
    localparam int DELAY = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_pin = '0;
    logic [7:0]  cfg_vector = '0;
    logic        cfg_level = 1'b0;
    logic        cfg_mask = 1'b1;
    logic [23:0] irq_line = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        dlv_valid;
    logic [7:0]  dlv_vector;
    logic        dlv_ready = 1'b1;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          e_cyc = 0;
    string       cur_req = "R3";
    logic [7:0]  exp_q[$];

    eoi_storm_throttle #(
        .NPINS(NPINS), .STORM_LIMIT(LIMIT), .DELAY_CYCLES(DELAY)
    ) i_eoi_storm_throttle (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
        .cfg_vector(cfg_vector), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
        .irq_line(irq_line), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_ready(dlv_ready)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every accepted delivery against the queue.
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dlv_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected delivery", dlv_vector, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(dlv_vector == e, cur_req, "delivered vector", dlv_vector, e);
            end
        end
    end

    task automatic cfg(input int pin, input logic [7:0] v, input logic lvl, input logic msk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pin = 5'(pin); cfg_vector = v; cfg_level = lvl; cfg_mask = msk;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        e_cyc = cyc + 1;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic expect_vec(input logic [7:0] v);
        exp_q.push_back(v);
    endtask

    task automatic drain(input string req);
        cur_req = req;
        for (int k = 0; k < 100 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, req, "deliveries missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (6) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        cur_req = req;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dlv_valid) seen++;
        end
        check(seen == 0, req, "valid cycles while quiet", seen, 0);
    endtask

    // Check silence until the deadline, then the delivery one cycle later.
    task automatic deadline(input int e, input logic [7:0] v, input string req);
        int seen = 0;
        cur_req = req;
        while (cyc < e + DELAY) begin
            @(negedge clk);
            if (dlv_valid) seen++;
        end
        check(seen == 0, req, "early delivery cycles", seen, 0);
        @(negedge clk);
        check(dlv_valid && dlv_vector == v, req, "delivery at deadline+1",
              {dlv_valid, dlv_vector}, {1'b1, v});
    endtask

    task automatic run_all();
        // R1: reset state, all lines high, nothing delivered.
        repeat (3) @(negedge clk);
        check(dlv_valid == 1'b0, "R1", "valid after reset", dlv_valid, 0);
        irq_line = '1;
        quiet(10, "R1");
        irq_line = '0;
        repeat (2) @(negedge clk);

        // R2/R3: level pin 3 delivers, edge pin 5 does not.
        cfg(3, 8'h41, 1'b1, 1'b0);
        cfg(5, 8'h50, 1'b0, 1'b0);
        cur_req = "R2/R3";
        expect_vec(8'h41);
        @(negedge clk);
        irq_line[3] = 1'b1; irq_line[5] = 1'b1;
        drain("R2/R3");

        // R4: wrong vector and edge-mode vector have no effect.
        eoi(8'h42);
        quiet(10, "R4");
        eoi(8'h50);
        quiet(10, "R4");
        // R5: matching EOI with line high re-raises (count 1, then 2).
        cur_req = "R5";
        expect_vec(8'h41); eoi(8'h41); drain("R5");
        expect_vec(8'h41); eoi(8'h41); drain("R5");

        // R6: line low at EOI, no re-raise and counter cleared.
        @(negedge clk); irq_line[3] = 1'b0;
        repeat (2) @(negedge clk);
        eoi(8'h41);
        quiet(10, "R6");
        cur_req = "R3";
        expect_vec(8'h41);
        @(negedge clk); irq_line[3] = 1'b1;
        drain("R3");
        for (int k = 0; k < LIMIT - 1; k++) begin
            cur_req = "R6";
            expect_vec(8'h41); eoi(8'h41); drain("R6");
        end

        // R7: the limit-th re-raise is deferred by exactly DELAY cycles.
        eoi(8'h41);
        expect_vec(8'h41);
        deadline(e_cyc, 8'h41, "R7");
        drain("R7");

        // R6: masked at EOI, then unmasked with steady line, no delivery.
        cfg(3, 8'h41, 1'b1, 1'b1);
        eoi(8'h41);
        quiet(10, "R6");
        cfg(3, 8'h41, 1'b1, 1'b0);
        quiet(10, "R6");

        // R11: simultaneous requests in ascending pin order.
        cfg(7, 8'h70, 1'b1, 1'b0);
        cfg(1, 8'h10, 1'b1, 1'b0);
        cur_req = "R11";
        expect_vec(8'h10); expect_vec(8'h70);
        @(negedge clk); irq_line[7] = 1'b1; irq_line[1] = 1'b1;
        drain("R11");

        // R12: shared vector above 23 on two pins, one EOI re-raises both.
        cfg(2, 8'hE9, 1'b1, 1'b0);
        cfg(9, 8'hE9, 1'b1, 1'b0);
        cur_req = "R12";
        expect_vec(8'hE9); expect_vec(8'hE9);
        @(negedge clk); irq_line[2] = 1'b1; irq_line[9] = 1'b1;
        drain("R12");
        expect_vec(8'hE9); expect_vec(8'hE9);
        eoi(8'hE9);
        drain("R12");

        // R10: one outstanding, held while ready is low.
        cfg(12, 8'hC0, 1'b1, 1'b0);
        cfg(4, 8'h44, 1'b1, 1'b0);
        dlv_ready = 1'b0;
        @(negedge clk); irq_line[12] = 1'b1;
        repeat (3) @(negedge clk);
        irq_line[4] = 1'b1;
        begin
            int bad = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (!(dlv_valid && dlv_vector == 8'hC0)) bad++;
            end
            check(bad == 0, "R10", "cycles not holding C0", bad, 0);
        end
        cur_req = "R10";
        expect_vec(8'hC0); expect_vec(8'h44);
        dlv_ready = 1'b1;
        drain("R10");

        // R8/R9: two storms share one timer; pass serves pins 1, 3, 7.
        for (int k = 0; k < LIMIT - 1; k++) begin
            cur_req = "R5";
            expect_vec(8'h10); eoi(8'h10); drain("R5");
            expect_vec(8'h70); eoi(8'h70); drain("R5");
        end
        eoi(8'h10);
        begin
            int first_e;
            first_e = e_cyc;
            expect_vec(8'h10); expect_vec(8'h41); expect_vec(8'h70);
            repeat (4) @(negedge clk);
            eoi(8'h70);
            deadline(first_e, 8'h10, "R8");
        end
        drain("R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule